// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request covering a whole 32-lane warp and turns it into the smallest set of aligned 128-byte line transactions. Every lane carries an enable bit and a byte address for a 4-byte word. Lanes whose addresses fall in the same 128-byte line are merged, so each distinct line touched by an active lane costs exactly one transaction.

A request is presented with `req_valid` while `req_ready` is high. The block is busy from that point until it has emitted every transaction. Transactions leave one per cycle over a valid/ready handshake. Each one carries the line base address and a 32-bit mask of the lanes it serves. When the final transaction is taken, a one-cycle `done` pulse follows.

A fully contiguous, aligned warp access costs one transaction. A scattered access costs up to 32. Lanes that are disabled generate no traffic at all. The block carries addresses only; data, caching and write merging belong to other logic.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high exactly when no transaction of an earlier request is outstanding. A request is taken only on a cycle with `req_valid` and `req_ready` both high, and `txn_valid` is never high on a cycle where `req_ready` is high.
- R2: `txn_line` equals the lane byte address with its low 7 bits forced to zero, which gives the base of a 128-byte aligned line.
- R3: Lanes that share a line are served by one transaction. Bit i of `txn_lanes` is set exactly when lane i is active and its address lies in that line.
- R4: A lane whose bit in `req_mask` is 0 never appears in any `txn_lanes` and adds no transaction.
- R5: Transactions come out in ascending order of the lowest-numbered lane that is still unserved.
- R6: At most one transaction is taken per cycle, on a cycle with `txn_valid` and `txn_ready` both high. While `txn_valid` is high and `txn_ready` is low, `txn_line` and `txn_lanes` hold their values.
- R7: `done` is high for one cycle: the cycle right after the handshake of the last transaction of a request.
- R8: A request with `req_mask` all zero issues no transaction and raises `done` in the cycle right after it is accepted.
- R9: Thirty-two consecutive words inside one aligned line cost one transaction. Lanes placed in 32 different lines cost 32 transactions.
- R10: After reset, `req_ready` is high and both `txn_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | Block is idle and can take a request |
| req_mask | input | 32 | Per-lane enable; bit i is lane i |
| req_addr | input | 1024 | Lane byte addresses; lane i at bits [32*i+31 : 32*i] |
| txn_valid | output | 1 | A line transaction is offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_line | output | 32 | Line base address (low 7 bits zero) |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the final transaction of a request |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that a stalled transaction stays unchanged, that the block is never offering work while it is also ready for a new request, and that every lane mask is non-empty and limited to lanes that were enabled. It also checks that a falling `txn_valid` always comes with `done`. Other behaviours need full knowledge of the addresses, so only the bench scenarios can show them: the correct merge of lanes by line, the ascending lowest-lane order, and the exact transaction counts for contiguous, strided, scattered, unaligned, half-masked and empty requests. The bench covers these with random backpressure.

// File: rtl/coal_pkg.sv
package coal_pkg;
    localparam int DEF_LANES      = 32;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_LINE_BYTES = 128;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_e;

    // Index of the lowest set bit; returns 0 for an all-zero vector.
    function automatic int unsigned lowest_set(input logic [DEF_LANES-1:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = DEF_LANES - 1; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction
endpackage

// File: rtl/coal_tag_store.sv
module coal_tag_store #(
    parameter int LANES = 32,
    parameter int TAG_W = 25
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [LANES*TAG_W-1:0] load_tags,
    input  logic [LANES-1:0]       load_mask,
    input  logic                   retire,
    input  logic [LANES-1:0]       retire_mask,
    output logic [LANES*TAG_W-1:0] tags,
    output logic [LANES-1:0]       pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (load) begin
            pending <= load_mask;
        end else if (retire) begin
            pending <= pending & ~retire_mask;
        end
    end

    // Line tags carry no reset: they are only read under a pending bit.
    always_ff @(posedge clk) begin
        if (load) tags <= load_tags;
    end
endmodule

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic [IDX_W-1:0] lead_idx,
    output logic             any
);
    always_comb begin
        lead_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) lead_idx = IDX_W'(i);
        end
    end

    assign any = |pending;
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
    parameter int LANES = 32,
    parameter int TAG_W = 25,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES*TAG_W-1:0] tags,
    input  logic [LANES-1:0]       pending,
    input  logic [IDX_W-1:0]       lead_idx,
    output logic [TAG_W-1:0]       lead_tag,
    output logic [LANES-1:0]       match
);
    assign lead_tag = tags[lead_idx*TAG_W +: TAG_W];

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign match[g] = pending[g] && (tags[g*TAG_W +: TAG_W] == lead_tag);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = DEF_LANES,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int LINE_BYTES = DEF_LINE_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_line,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    done
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int IDX_W = $clog2(LANES);

    coal_state_e            state;
    logic [LANES*TAG_W-1:0] in_tags;
    logic [LANES*TAG_W-1:0] tags;
    logic [LANES-1:0]       pending;
    logic [LANES-1:0]       match;
    logic [IDX_W-1:0]       lead_idx;
    logic [TAG_W-1:0]       lead_tag;
    logic                   any_pending;
    logic                   accept;
    logic                   fire;
    logic                   last_fire;

    for (genvar g = 0; g < LANES; g++) begin : g_tag
        assign in_tags[g*TAG_W +: TAG_W] = req_addr[g*ADDR_W + OFS_W +: TAG_W];
    end

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign txn_valid = (state == ST_ISSUE) && any_pending;
    assign fire      = txn_valid && txn_ready;
    assign last_fire = fire && ((pending & ~match) == '0);
    assign txn_line  = {lead_tag, {OFS_W{1'b0}}};
    assign txn_lanes = match;

    coal_tag_store #(.LANES(LANES), .TAG_W(TAG_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .load_tags   (in_tags),
        .load_mask   (req_mask),
        .retire      (fire),
        .retire_mask (match),
        .tags        (tags),
        .pending     (pending)
    );

    coal_lead_pick #(.LANES(LANES)) u_pick (
        .pending  (pending),
        .lead_idx (lead_idx),
        .any      (any_pending)
    );

    coal_line_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
        .tags     (tags),
        .pending  (pending),
        .lead_idx (lead_idx),
        .lead_tag (lead_tag),
        .match    (match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_mask == '0) done <= 1'b1;
                        else                state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (last_fire) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_mask,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [ADDR_W-1:0] txn_line,
    input logic [LANES-1:0]  txn_lanes,
    input logic              done
);
    logic [LANES-1:0] held_mask;

    always_ff @(posedge clk) begin
        if (rst) held_mask <= '0;
        else if (req_valid && req_ready) held_mask <= req_mask;
    end

    // R1
    busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(txn_valid && req_ready));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_lanes)));

    // R3
    lanes_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_lanes != '0));

    // R4
    lanes_active_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> ((txn_lanes & ~held_mask) == '0));

    // R7
    done_on_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txn_valid) |-> done);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !txn_valid));
endmodule

bind warp_coalescer coal_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_line  (txn_line),
    .txn_lanes (txn_lanes),
    .done      (done)
);

// File: tb/tb_warp_coalescer.sv
`timescale 1ns/1ps
module tb_warp_coalescer;
    localparam int L = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [L-1:0]    req_mask = '0;
    logic [L*32-1:0] req_addr = '0;
    logic            txn_valid;
    logic            txn_ready = 1'b0;
    logic [31:0]     txn_line;
    logic [L-1:0]    txn_lanes;
    logic            done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit ready_always = 0;

    // reference model state
    bit          m_busy = 0;
    bit          m_done = 0;
    logic [31:0] q_line[$];
    logic [31:0] q_lanes[$];
    int          hs_cnt = 0;
    int          last_cnt = -1;
    int          exp_cnt = 0;

    logic [31:0] a_arr [L];

    always #2 clk = ~clk;

    warp_coalescer dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_line(txn_line), .txn_lanes(txn_lanes),
        .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle reference: compare, then predict the next edge
    always @(negedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; q_line.delete(); q_lanes.delete();
        end else begin
            check(req_ready == !m_busy, "R1 req_ready", req_ready, !m_busy);
            check(txn_valid == (q_line.size() > 0), "R6 txn_valid", txn_valid, q_line.size() > 0);
            if (txn_valid && q_line.size() > 0) begin
                check(txn_line == q_line[0], "R2/R5 txn_line", txn_line, q_line[0]);
                check(txn_lanes == q_lanes[0], "R3/R4 txn_lanes", txn_lanes, q_lanes[0]);
            end
            check(done == m_done, "R7 done", done, m_done);

            m_done = 0;
            if (!m_busy && req_valid) begin
                bit taken [L];
                logic [31:0] ln, a;
                logic [31:0] m;
                hs_cnt = 0;
                for (int l = 0; l < L; l++) taken[l] = 0;
                for (int l = 0; l < L; l++) begin
                    if (req_mask[l] && !taken[l]) begin
                        ln = req_addr[l*32 +: 32] & 32'hFFFF_FF80;
                        m = '0;
                        for (int k = l; k < L; k++) begin
                            a = req_addr[k*32 +: 32] & 32'hFFFF_FF80;
                            if (req_mask[k] && a == ln) begin
                                m[k] = 1'b1;
                                taken[k] = 1;
                            end
                        end
                        q_line.push_back(ln);
                        q_lanes.push_back(m);
                    end
                end
                exp_cnt = q_line.size();
                if (q_line.size() == 0) begin
                    m_done = 1;
                    last_cnt = 0;
                end else begin
                    m_busy = 1;
                end
            end else if (m_busy && txn_ready && q_line.size() > 0) begin
                void'(q_line.pop_front());
                void'(q_lanes.pop_front());
                hs_cnt++;
                if (q_line.size() == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    last_cnt = hs_cnt;
                end
            end
        end
    end

    // backpressure driver
    initial begin
        forever begin
            @(posedge clk);
            #1 txn_ready = ready_always ? 1'b1 : (($urandom % 4) != 0);
        end
    end

    task automatic run_req(input logic [L-1:0] mask, input int want, input string tag);
        int guard;
        @(posedge clk); #1;
        for (int i = 0; i < L; i++) req_addr[i*32 +: 32] = a_arr[i];
        req_mask = mask;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!done && guard < 2000);
        check(guard < 2000, {tag, " completion"}, guard, 0);
        if (want >= 0)
            check(last_cnt == want, {tag, " count"}, last_cnt, want);
        else
            check(last_cnt == exp_cnt, {tag, " count"}, last_cnt, exp_cnt);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
        check(txn_valid == 1'b0, "R10 txn_valid", txn_valid, 0);
        check(done == 1'b0, "R10 done", done, 0);

        // R9 contiguous aligned: one transaction
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0000_1000 + 4*i;
        run_req('1, 1, "R9 contiguous");
        // R9 scattered: one per lane
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0010_0000 + 32'h1000*i + 4;
        run_req('1, 32, "R9 scattered");
        // R3 stride of a whole line: 32 lines
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0000_8000 + 128*i;
        run_req('1, 32, "R3 stride32");
        // R3 stride of two words: 2 lines
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0000_2000 + 8*i;
        run_req('1, 2, "R3 stride2");
        // R2 unaligned contiguous base spans 2 lines
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0000_3040 + 4*i;
        run_req('1, 2, "R2 unaligned");
        // R8 empty mask
        run_req('0, 0, "R8 empty");
        // R4 half mask of scattered lanes
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0020_0000 + 32'h400*i;
        run_req(32'h5555_5555, 16, "R4 halfmask");
        // R5 interleaved lines out of address order
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0000_5000 + 128*(3 - (i % 4)) + 4*(i / 4);
        run_req('1, 4, "R5 interleave");
        // R6 full-throughput run
        ready_always = 1;
        for (int i = 0; i < L; i++) a_arr[i] = 32'h0000_9000 + 128*(i % 5);
        run_req('1, 5, "R6 streaming");
        ready_always = 0;
        // R1 random requests over a small line pool
        for (int r = 0; r < 40; r++) begin
            for (int i = 0; i < L; i++) a_arr[i] = 32'h0004_0000 + 128*($urandom % 6) + 4*($urandom % 32);
            run_req($urandom, -1, "R1 random");
        end
        // R8 back-to-back empty requests
        run_req('0, 0, "R8 empty2");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule